// File: doc/BRIEF.md
# Programmable Source-to-Slot Switch Matrix with Wired-AND Merge

This block is the routing fabric that feeds the input slots of a group of function blocks. Every I/O cell input and every function-block output is a source. Each function block owns a fixed number of input slots, and each slot is told by its own configuration entry what to present: a constant 1, one chosen source, or the AND of a chosen subset of function-block outputs. I/O cell sources can never enter such a merge.

The configuration lives in static registers written one slot per clock through a write port made of a strobe, a slot address and the slot's new fields. The path from sources to slots has no register on it. Every slot is built from the same selection structure, so every source-to-slot path has the same logic depth whatever routing is chosen. The number of slots per function block has a hard cap of 36, enforced when the design is elaborated.

Top module: `route_matrix`

## Requirements
- R1: After reset every slot output `fb_in` is 1.
- R2: A slot whose mode code is 0 (off) or 3 (spare) outputs 1.
- R3: A slot in mode code 1 (pick) outputs the source whose index it holds: index i below N_IO selects `io_in[i]`; index N_IO + k*FB_OUTS + j selects output j of function block k, that is `fb_out[k*FB_OUTS + j]`. Any source may go to any slot.
- R4: A slot in pick mode whose source index is N_IO + N_FB*FB_OUTS or larger outputs 1.
- R5: A slot in mode code 2 (merge) outputs the AND of every `fb_out` bit whose mask bit is set; mask bit k*FB_OUTS + j stands for output j of function block k.
- R6: A merge slot whose mask has no bit set outputs 1.
- R7: The output of a merge slot does not depend on `io_in`.
- R8: A write takes effect at the clock edge where `cfg_we` is sampled high; until that edge the slot keeps its old routing, and with `cfg_we` low no slot changes.
- R9: A write whose address is N_FB*SLOTS_PER_FB or larger changes no slot.
- R10: Slot s of function block f has address f*SLOTS_PER_FB + s and drives `fb_in[f*SLOTS_PER_FB + s]`; SLOTS_PER_FB must lie between 1 and 36.
- R11: A change on a source reaches the slots that use it without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| io_in | input | N_IO | Signals arriving from the I/O cells |
| fb_out | input | N_FB*FB_OUTS | Outputs of all function blocks |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | $clog2(N_FB*SLOTS_PER_FB) | Slot address of the write |
| cfg_mode | input | 2 | Slot mode: 0 off, 1 pick, 2 merge, 3 spare |
| cfg_src | input | $clog2(N_IO+N_FB*FB_OUTS) | Source index used in pick mode |
| cfg_mask | input | N_FB*FB_OUTS | Merge mask over function-block outputs |
| fb_in | output | N_FB*SLOTS_PER_FB | Slot outputs to the function blocks |

## Verification
The bench builds the block with its defaults: 8 I/O inputs, 4 function blocks with 4 outputs and 6 slots each. That gives 24 sources behind a 5-bit index and 24 slots behind a 5-bit address, so eight out-of-range source codes (R4) and eight unmapped addresses (R9) can be driven. The array is small enough for every slot to be compared against a reference model after each write, and every source can be routed to a slot in a directed sweep.

// File: rtl/route_pkg.sv
package route_pkg;
    typedef enum logic [1:0] {
        SLOT_OFF   = 2'd0,
        SLOT_PICK  = 2'd1,
        SLOT_MERGE = 2'd2,
        SLOT_SPARE = 2'd3
    } slot_mode_e;

    localparam int FANIN_CAP = 36;
endpackage

// File: rtl/route_cfg_store.sv
module route_cfg_store #(
    parameter int NSLOT = 24,
    parameter int SLOTW = 5,
    parameter int SRCW  = 5,
    parameter int MASKW = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [SLOTW-1:0]                 addr,
    input  logic [1:0]                       mode,
    input  logic [SRCW-1:0]                  src,
    input  logic [MASKW-1:0]                 mask,
    output logic [NSLOT-1:0][1:0]            mode_q,
    output logic [NSLOT-1:0][SRCW-1:0]       src_q,
    output logic [NSLOT-1:0][MASKW-1:0]      mask_q
);
    localparam logic [SLOTW:0] NSLOT_W = NSLOT[SLOTW:0];

    logic addr_ok;
    assign addr_ok = ({1'b0, addr} < NSLOT_W);

    // One slot entry per write; out-of-range addresses are dropped (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            src_q  <= '0;
            mask_q <= '0;
        end else if (we && addr_ok) begin
            mode_q[addr] <= mode;
            src_q[addr]  <= src;
            mask_q[addr] <= mask;
        end
    end
endmodule

// File: rtl/route_slot.sv
module route_slot
    import route_pkg::*;
#(
    parameter int NSRC  = 24,
    parameter int SRCW  = 5,
    parameter int MASKW = 16
) (
    input  logic [NSRC-1:0]  src_all,
    input  logic [MASKW-1:0] fb_all,
    input  logic [1:0]       mode,
    input  logic [SRCW-1:0]  src,
    input  logic [MASKW-1:0] mask,
    output logic             y
);
    localparam logic [SRCW:0] NSRC_W = NSRC[SRCW:0];

    slot_mode_e sel;
    logic       picked;
    logic       merged;

    assign sel = slot_mode_e'(mode);

    always_comb begin
        picked = 1'b1;
        if ({1'b0, src} < NSRC_W) begin
            picked = src_all[src];
        end
    end

    // Only function-block outputs exist in the merge operand
    assign merged = &(fb_all | ~mask);

    always_comb begin
        unique case (sel)
            SLOT_PICK:  y = picked;
            SLOT_MERGE: y = merged;
            SLOT_OFF:   y = 1'b1;
            SLOT_SPARE: y = 1'b1;
            default:    y = 1'b1;
        endcase
    end
endmodule

// File: rtl/route_matrix.sv
module route_matrix
    import route_pkg::*;
#(
    parameter int N_IO         = 8,
    parameter int N_FB         = 4,
    parameter int FB_OUTS      = 4,
    parameter int SLOTS_PER_FB = 6,
    localparam int NSLOT       = N_FB * SLOTS_PER_FB,
    localparam int MASKW       = N_FB * FB_OUTS,
    localparam int NSRC        = N_IO + MASKW,
    localparam int SLOTW       = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int SRCW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_IO-1:0]    io_in,
    input  logic [MASKW-1:0]   fb_out,
    input  logic               cfg_we,
    input  logic [SLOTW-1:0]   cfg_addr,
    input  logic [1:0]         cfg_mode,
    input  logic [SRCW-1:0]    cfg_src,
    input  logic [MASKW-1:0]   cfg_mask,
    output logic [NSLOT-1:0]   fb_in
);
    // Hard per-function-block fan-in limit (R10)
    if (SLOTS_PER_FB < 1 || SLOTS_PER_FB > FANIN_CAP) begin : g_fanin_bad
        $error("route_matrix: SLOTS_PER_FB outside 1..36");
    end

    logic [NSLOT-1:0][1:0]       mode_q;
    logic [NSLOT-1:0][SRCW-1:0]  src_q;
    logic [NSLOT-1:0][MASKW-1:0] mask_q;
    logic [NSRC-1:0]             src_all;

    assign src_all = {fb_out, io_in};

    route_cfg_store #(
        .NSLOT (NSLOT),
        .SLOTW (SLOTW),
        .SRCW  (SRCW),
        .MASKW (MASKW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .mode   (cfg_mode),
        .src    (cfg_src),
        .mask   (cfg_mask),
        .mode_q (mode_q),
        .src_q  (src_q),
        .mask_q (mask_q)
    );

    // Identical structure for every slot: uniform depth on every path
    for (genvar f = 0; f < N_FB; f++) begin : g_fb
        for (genvar s = 0; s < SLOTS_PER_FB; s++) begin : g_slot
            localparam int A = f * SLOTS_PER_FB + s;
            route_slot #(
                .NSRC  (NSRC),
                .SRCW  (SRCW),
                .MASKW (MASKW)
            ) u_slot (
                .src_all (src_all),
                .fb_all  (fb_out),
                .mode    (mode_q[A]),
                .src     (src_q[A]),
                .mask    (mask_q[A]),
                .y       (fb_in[A])
            );
        end
    end
endmodule

// File: rtl/route_matrix_chk.sv
module route_matrix_chk #(
    parameter int N_IO  = 8,
    parameter int NSLOT = 24,
    parameter int MASKW = 16,
    parameter int NSRC  = 24,
    parameter int SLOTW = 5,
    parameter int SRCW  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_IO-1:0]  io_in,
    input logic [MASKW-1:0] fb_out,
    input logic             cfg_we,
    input logic [SLOTW-1:0] cfg_addr,
    input logic [1:0]       cfg_mode,
    input logic [SRCW-1:0]  cfg_src,
    input logic [MASKW-1:0] cfg_mask,
    input logic [NSLOT-1:0] fb_in
);
    localparam logic [SLOTW:0] NSLOT_W = NSLOT[SLOTW:0];
    localparam logic [SRCW:0]  NSRC_W  = NSRC[SRCW:0];

    logic [NSRC-1:0] srcs;
    logic            addr_ok;
    logic            src_ok;
    assign srcs    = {fb_out, io_in};
    assign addr_ok = ({1'b0, cfg_addr} < NSLOT_W);
    assign src_ok  = ({1'b0, cfg_src} < NSRC_W);

    assert_reset_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&fb_in));

    assert_off_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok && (cfg_mode == 2'd0 || cfg_mode == 2'd3))
        |=> fb_in[$past(cfg_addr)]);

    // R3 and R4: pick mode follows the source, or 1 when out of range
    assert_pick_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok && cfg_mode == 2'd1 && src_ok)
        |=> fb_in[$past(cfg_addr)] == srcs[$past(cfg_src)]);

    assert_pick_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok && cfg_mode == 2'd1 && !src_ok)
        |=> fb_in[$past(cfg_addr)]);

    // R5, R6, R7: merge uses function-block outputs only
    assert_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && addr_ok && cfg_mode == 2'd2)
        |=> fb_in[$past(cfg_addr)] == (&(fb_out | ~$past(cfg_mask))));

    // R8 and R9: without an accepted write, stable sources keep slots stable
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!$past(cfg_we) || !$past(addr_ok)) && $stable(io_in) && $stable(fb_out))
        |-> $stable(fb_in));
endmodule

bind route_matrix route_matrix_chk #(
    .N_IO  (N_IO),
    .NSLOT (NSLOT),
    .MASKW (MASKW),
    .NSRC  (NSRC),
    .SLOTW (SLOTW),
    .SRCW  (SRCW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_in    (io_in),
    .fb_out   (fb_out),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_mode (cfg_mode),
    .cfg_src  (cfg_src),
    .cfg_mask (cfg_mask),
    .fb_in    (fb_in)
);

// File: tb/test_route_matrix.sv
module test_route_matrix;
    localparam int N_IO  = 8;
    localparam int N_FB  = 4;
    localparam int FBO   = 4;
    localparam int SPF   = 6;
    localparam int NSLOT = N_FB * SPF;
    localparam int MASKW = N_FB * FBO;
    localparam int NSRC  = N_IO + MASKW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IO-1:0]  io_v = '0;
    logic [MASKW-1:0] fb_v = '0;
    logic             cfg_we = 1'b0;
    logic [4:0]       cfg_addr = '0;
    logic [1:0]       cfg_mode = '0;
    logic [4:0]       cfg_src = '0;
    logic [MASKW-1:0] cfg_mask = '0;
    logic [NSLOT-1:0] fb_in;

    int nchk = 0;
    int nbad = 0;
    int m_mode [NSLOT];
    int m_src  [NSLOT];
    logic [MASKW-1:0] m_mask [NSLOT];

    always #2 clk = ~clk;

    route_matrix #(.N_IO(N_IO), .N_FB(N_FB), .FB_OUTS(FBO), .SLOTS_PER_FB(SPF)) i_route_matrix (
        .clk(clk), .rst_n(rst_n), .io_in(io_v), .fb_out(fb_v),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_mode(cfg_mode),
        .cfg_src(cfg_src), .cfg_mask(cfg_mask), .fb_in(fb_in)
    );

    function automatic logic exp_slot(int a);
        logic [NSRC-1:0] s;
        s = {fb_v, io_v};
        case (m_mode[a])
            1: return (m_src[a] < NSRC) ? s[m_src[a]] : 1'b1;
            2: return &(fb_v | ~m_mask[a]);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check_bit(string req, int a, logic exp);
        nchk++;
        if (fb_in[a] !== exp) begin
            nbad++;
            $display("FAIL %s slot %0d: actual %b expected %b", req, a, fb_in[a], exp);
        end
    endtask

    task automatic check_all(string req);
        for (int a = 0; a < NSLOT; a++) check_bit(req, a, exp_slot(a));
    endtask

    task automatic wr(int addr, int mode, int src, logic [MASKW-1:0] mask);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr[4:0]; cfg_mode = mode[1:0];
        cfg_src = src[4:0]; cfg_mask = mask;
        @(posedge clk);
        if (addr < NSLOT) begin
            m_mode[addr] = mode; m_src[addr] = src; m_mask[addr] = mask;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < NSLOT; a++) begin m_mode[a] = 0; m_src[a] = 0; m_mask[a] = '0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < NSLOT; a++) check_bit("R1", a, 1'b1);
    endtask

    task automatic t_pick_sweep();
        // R3 / R10: every source lands on a distinct slot address
        for (int s = 0; s < NSRC; s++) wr(s % NSLOT, 1, s, '0);
        for (int p = 0; p < 4; p++) begin
            io_v = $urandom(); fb_v = $urandom();
            @(negedge clk);
            check_all("R3");
            check_all("R10");
        end
    endtask

    task automatic t_off_spare();
        io_v = '0; fb_v = '0;
        wr(2, 0, 0, '0);
        wr(NSLOT - 1, 3, 0, '0);
        check_bit("R2", 2, 1'b1);
        check_bit("R2", NSLOT - 1, 1'b1);
    endtask

    task automatic t_range();
        io_v = '0; fb_v = '0;
        wr(4, 1, NSRC, '0);
        wr(5, 1, 31, '0);
        check_bit("R4", 4, 1'b1);
        check_bit("R4", 5, 1'b1);
    endtask

    task automatic t_merge();
        wr(6, 2, 0, 16'h00F0);
        fb_v = 16'h00F0; @(negedge clk); check_bit("R5", 6, 1'b1);
        fb_v = 16'hFFB0; @(negedge clk); check_bit("R5", 6, 1'b0);
        wr(7, 2, 0, 16'h0000);
        fb_v = '0; @(negedge clk); check_bit("R6", 7, 1'b1);
    endtask

    task automatic t_io_excl();
        wr(8, 2, 0, 16'hFFFF);
        wr(9, 2, 0, 16'h0001);
        fb_v = 16'hFFFF;
        for (int i = 0; i < 6; i++) begin
            io_v = $urandom(); @(negedge clk);
            check_bit("R7", 8, 1'b1);
        end
        fb_v = 16'hFFFE;
        for (int i = 0; i < 6; i++) begin
            io_v = $urandom(); @(negedge clk);
            check_bit("R7", 9, 1'b0);
        end
    endtask

    task automatic t_timing();
        wr(10, 0, 0, '0);
        io_v = '0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'd10; cfg_mode = 2'd1; cfg_src = 5'd0; cfg_mask = '0;
        #1 check_bit("R8", 10, 1'b1);
        @(posedge clk);
        m_mode[10] = 1; m_src[10] = 0;
        #1 check_bit("R8", 10, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0; cfg_mode = 2'd0; cfg_addr = 5'd10;
        repeat (2) @(negedge clk);
        check_bit("R8", 10, 1'b0);
    endtask

    task automatic t_oob();
        io_v = '0; fb_v = '0;
        for (int a = NSLOT; a < 32; a++) wr(a, 0, 0, '0);
        check_all("R9");
        for (int a = NSLOT; a < 32; a++) wr(a, 2, 0, 16'hFFFF);
        check_all("R9");
    endtask

    task automatic t_comb();
        wr(11, 1, N_IO + 5, '0);
        fb_v = '0; @(negedge clk);
        fb_v[5] = 1'b1;
        #1 check_bit("R11", 11, 1'b1);
        fb_v[5] = 1'b0;
        #1 check_bit("R11", 11, 1'b0);
    endtask

    task automatic t_random();
        for (int it = 0; it < 40; it++) begin
            for (int k = 0; k < 4; k++)
                wr($urandom_range(0, 31), $urandom_range(0, 3), $urandom_range(0, 31), MASKW'($urandom()));
            for (int p = 0; p < 3; p++) begin
                io_v = $urandom(); fb_v = $urandom() | $urandom();
                @(negedge clk);
                check_all("R3/R5 random");
            end
        end
    endtask

    initial begin
        t_reset();
        t_pick_sweep();
        t_off_spare();
        t_range();
        t_merge();
        t_io_excl();
        t_timing();
        t_oob();
        t_comb();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule